// File: doc/BRIEF.md
# I2C Master Address-Phase Sequencer

This block runs the addressing part of an I2C master transaction. Software, or a wrapping register block, writes a control word. The word carries a start request, a 10-bit mode switch, the transfer direction, a header-only option and a 10-bit slave address. The sequencer turns that word into an ordered list of bus commands: START, RESTART, or send one byte. It hands the commands one at a time to a byte-level bus engine and reads back the acknowledge that the engine reports for each.

The engine side uses a simple handshake. The sequencer holds `cmd_valid` with an operation code and a byte until `cmd_ready` is seen. The engine later returns one `rsp_valid` beat per command, with `rsp_ack` giving the acknowledge bit. For START and RESTART the acknowledge bit carries no meaning.

The sequence ends in one of three ways. The last address byte is acknowledged (`done`). An address byte is not acknowledged (`nack`). Or it is cut short by arbitration loss, timeout or loss of the block enable. The pending start request drops in every one of these cases, and `start_clr` marks the cycle in which it drops.

Top module: `i2c_addr_seq`

## Requirements
- R1: After a synchronous reset, `start_pend`, `cmd_valid`, `done`, `nack` and `start_clr` are 0 and the stored fields `cur_*` are 0.
- R2: With 10-bit mode off, the commands are START (op 0) and then a send (op 2) of the byte {addr[7:1], rd}. Address bits 9, 8 and 0 do not affect any byte.
- R3: With 10-bit mode on and rd=0, the commands are START, then send {5'b11110, addr[9:8], 1'b0}, then send addr[7:0], with no RESTART. The header-only option has no effect here.
- R4: With 10-bit mode on, rd=1 and the header-only option clear, the commands are START, send {11110, addr[9:8], 0}, send addr[7:0], RESTART (op 1), send {11110, addr[9:8], 1}.
- R5: With 10-bit mode on, rd=1 and the header-only option set, the commands are only RESTART followed by send {11110, addr[9:8], 1}.
- R6: When the response to the last address byte carries an acknowledge, `done` is high for exactly one cycle. In that same cycle `start_pend` is 0 and `start_clr` is 1.
- R7: A response with `rsp_ack`=0 to any send command raises `nack` for one cycle, clears `start_pend`, pulses `start_clr`, and no further command is issued. A response with `rsp_ack`=0 to START or RESTART is not an error.
- R8: While a request is pending, `arb_lost`, `timeout` or `enable`=0 in a cycle clears `start_pend` and `cmd_valid` at the next edge, with `start_clr` high. A start write while `enable`=0 does not set `start_pend`.
- R9: While `start_pend` is 1, control writes change none of `cur_ten_bit`, `cur_rd`, `cur_hdr_only` and `cur_addr`, and they do not alter the command bytes of the running sequence.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0 (with no abort), `cmd_valid`, `cmd_op` and `cmd_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low aborts a pending request |
| cfg_we | input | 1 | Control word write strobe |
| cfg_start | input | 1 | Start request bit of the written word |
| cfg_ten_bit | input | 1 | 10-bit addressing enable of the written word |
| cfg_rd | input | 1 | Direction: 0 transmit, 1 receive |
| cfg_hdr_only | input | 1 | Header-only read option for 10-bit receive |
| cfg_addr | input | 10 | Slave address of the written word |
| arb_lost | input | 1 | Arbitration lost indication from the bus engine |
| timeout | input | 1 | Timeout indication |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 0 START, 1 RESTART, 2 send byte |
| cmd_byte | output | 8 | Byte to send when `cmd_op` is 2 |
| rsp_valid | input | 1 | Byte engine finished the accepted command |
| rsp_ack | input | 1 | Acknowledge bit of the finished command |
| start_pend | output | 1 | Start request pending |
| start_clr | output | 1 | One-cycle pulse when the start request is cleared |
| done | output | 1 | One-cycle pulse: address phase complete |
| nack | output | 1 | One-cycle pulse: address byte not acknowledged |
| cur_ten_bit | output | 1 | Stored 10-bit enable |
| cur_rd | output | 1 | Stored direction |
| cur_hdr_only | output | 1 | Stored header-only option |
| cur_addr | output | 10 | Stored slave address |

## Verification
The bench sweeps all 1024 address values through all five sequence shapes. This catches a sequencer that leaks address bits 9, 8 or 0 into the 7-bit byte, swaps the header read/write bit, or emits a RESTART in 10-bit transmit. The bench also answers START and RESTART with a missing acknowledge, so a design that treats that as an error aborts early. NACKs are injected on the header, the second byte and the final read header, and aborts are injected both while a command is offered and while a response is awaited. A design that keeps issuing commands, or that leaves the request pending, then fails. Writes made during a pending request must leave both the stored fields and the bytes on the bus untouched.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam logic [4:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_SEND    = 2'd2
  } bus_op_e;

  typedef enum logic [1:0] {
    SEQ_7B,
    SEQ_10_TX,
    SEQ_10_RX,
    SEQ_10_HDR
  } seq_e;

  typedef struct packed {
    logic              ten_bit;
    logic              rd;
    logic              hdr_only;
    logic [ADDR_W-1:0] addr;
  } addr_cfg_t;

  typedef struct packed {
    bus_op_e           op;
    logic [BYTE_W-1:0] data;
    logic              last;
  } step_t;

endpackage

// File: rtl/i2c_addr_cfg.sv
module i2c_addr_cfg
  import i2c_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      wr_en,
  input  logic      wr_start,
  input  addr_cfg_t wr_cfg,
  input  logic      clr,
  output logic      pend,
  output addr_cfg_t cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cfg  <= '0;
    end else begin
      if (clr) begin
        pend <= 1'b0;
      end else if (wr_en && !pend && enable && wr_start) begin
        pend <= 1'b1;
      end
      if (wr_en && !pend) begin
        cfg <= wr_cfg;
      end
    end
  end

endmodule

// File: rtl/i2c_addr_step.sv
module i2c_addr_step
  import i2c_addr_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  addr_cfg_t         cfg,
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);

  seq_e              shape;
  logic [BYTE_W-1:0] hdr_w;
  logic [BYTE_W-1:0] hdr_r;
  logic [BYTE_W-1:0] short_b;
  logic [BYTE_W-1:0] low_b;

  always_comb begin
    if (!cfg.ten_bit)       shape = SEQ_7B;
    else if (!cfg.rd)       shape = SEQ_10_TX;
    else if (cfg.hdr_only)  shape = SEQ_10_HDR;
    else                    shape = SEQ_10_RX;
  end

  assign hdr_w   = {HDR_PREFIX, cfg.addr[ADDR_W-1:ADDR_W-2], 1'b0};
  assign hdr_r   = {HDR_PREFIX, cfg.addr[ADDR_W-1:ADDR_W-2], 1'b1};
  assign short_b = {cfg.addr[BYTE_W-1:1], cfg.rd};
  assign low_b   = cfg.addr[BYTE_W-1:0];

  always_comb begin
    step = '{op: OP_START, data: '0, last: 1'b1};
    unique case (shape)
      SEQ_7B: begin
        case (idx)
          STEP_W'(0): step = '{op: OP_START, data: '0,      last: 1'b0};
          default:    step = '{op: OP_SEND,  data: short_b, last: 1'b1};
        endcase
      end
      SEQ_10_TX: begin
        case (idx)
          STEP_W'(0): step = '{op: OP_START, data: '0,    last: 1'b0};
          STEP_W'(1): step = '{op: OP_SEND,  data: hdr_w, last: 1'b0};
          default:    step = '{op: OP_SEND,  data: low_b, last: 1'b1};
        endcase
      end
      SEQ_10_RX: begin
        case (idx)
          STEP_W'(0): step = '{op: OP_START,   data: '0,    last: 1'b0};
          STEP_W'(1): step = '{op: OP_SEND,    data: hdr_w, last: 1'b0};
          STEP_W'(2): step = '{op: OP_SEND,    data: low_b, last: 1'b0};
          STEP_W'(3): step = '{op: OP_RESTART, data: '0,    last: 1'b0};
          default:    step = '{op: OP_SEND,    data: hdr_r, last: 1'b1};
        endcase
      end
      SEQ_10_HDR: begin
        case (idx)
          STEP_W'(0): step = '{op: OP_RESTART, data: '0,    last: 1'b0};
          default:    step = '{op: OP_SEND,    data: hdr_r, last: 1'b1};
        endcase
      end
      default: step = '{op: OP_START, data: '0, last: 1'b1};
    endcase
  end

endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_addr_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend,
  input  logic              abort,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  step_t             step_in,
  output logic [STEP_W-1:0] step_sel,
  output logic              cmd_valid,
  output bus_op_e           cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              done,
  output logic              nack,
  output logic              finish
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e            state;
  logic [STEP_W-1:0] idx;
  logic              cur_last;
  logic              byte_nack;

  assign step_sel  = (state == S_IDLE) ? '0 : idx + STEP_W'(1);
  assign byte_nack = (cmd_op == OP_SEND) && !rsp_ack;
  assign finish    = (state == S_WAIT) && rsp_valid && !abort && (byte_nack || cur_last);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    nack <= 1'b0;
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      cur_last  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_START;
      cmd_byte  <= '0;
    end else if (abort) begin
      state     <= S_IDLE;
      cmd_valid <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (pend) begin
            idx       <= '0;
            cmd_op    <= step_in.op;
            cmd_byte  <= step_in.data;
            cur_last  <= step_in.last;
            cmd_valid <= 1'b1;
            state     <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state     <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (rsp_valid) begin
            if (byte_nack) begin
              nack  <= 1'b1;
              state <= S_IDLE;
            end else if (cur_last) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              idx       <= step_sel;
              cmd_op    <= step_in.op;
              cmd_byte  <= step_in.data;
              cur_last  <= step_in.last;
              cmd_valid <= 1'b1;
              state     <= S_ISSUE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_addr_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic              cfg_start,
  input  logic              cfg_ten_bit,
  input  logic              cfg_rd,
  input  logic              cfg_hdr_only,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              arb_lost,
  input  logic              timeout,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  output logic              start_pend,
  output logic              start_clr,
  output logic              done,
  output logic              nack,
  output logic              cur_ten_bit,
  output logic              cur_rd,
  output logic              cur_hdr_only,
  output logic [ADDR_W-1:0] cur_addr
);

  addr_cfg_t         wr_cfg;
  addr_cfg_t         cfg;
  step_t             step;
  logic [STEP_W-1:0] step_sel;
  logic              pend;
  logic              abort;
  logic              finish;
  bus_op_e           op_q;

  assign wr_cfg = '{ten_bit: cfg_ten_bit, rd: cfg_rd, hdr_only: cfg_hdr_only, addr: cfg_addr};
  assign abort  = pend && (arb_lost || timeout || !enable);

  i2c_addr_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .wr_en    (cfg_we),
    .wr_start (cfg_start),
    .wr_cfg   (wr_cfg),
    .clr      (abort || finish),
    .pend     (pend),
    .cfg      (cfg)
  );

  i2c_addr_step #(.STEP_W(STEP_W)) u_step (
    .cfg  (cfg),
    .idx  (step_sel),
    .step (step)
  );

  i2c_addr_fsm #(.STEP_W(STEP_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .abort     (abort),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .step_in   (step),
    .step_sel  (step_sel),
    .cmd_valid (cmd_valid),
    .cmd_op    (op_q),
    .cmd_byte  (cmd_byte),
    .done      (done),
    .nack      (nack),
    .finish    (finish)
  );

  always_ff @(posedge clk) begin
    if (rst) start_clr <= 1'b0;
    else     start_clr <= pend && (abort || finish);
  end

  assign cmd_op       = op_q;
  assign start_pend   = pend;
  assign cur_ten_bit  = cfg.ten_bit;
  assign cur_rd       = cfg.rd;
  assign cur_hdr_only = cfg.hdr_only;
  assign cur_addr     = cfg.addr;

endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       arb_lost,
  input logic       timeout,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       start_pend,
  input logic       start_clr,
  input logic       done,
  input logic       nack,
  input logic       cur_ten_bit,
  input logic       cur_rd,
  input logic       cur_hdr_only,
  input logic [9:0] cur_addr
);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!start_pend && start_clr && !nack));

  assert_nack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    nack |-> (!start_pend && start_clr && !cmd_valid));

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (start_pend && (arb_lost || timeout || !enable)) |=> (!start_pend && !cmd_valid && start_clr));

  assert_cmd_needs_pend_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> start_pend);

  assert_fields_locked_R9: assert property (@(posedge clk) disable iff (rst)
    start_pend |=> ($stable(cur_addr) && $stable(cur_rd) && $stable(cur_ten_bit) && $stable(cur_hdr_only)));

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && enable && !arb_lost && !timeout)
      |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .arb_lost     (arb_lost),
  .timeout      (timeout),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .cmd_byte     (cmd_byte),
  .start_pend   (start_pend),
  .start_clr    (start_clr),
  .done         (done),
  .nack         (nack),
  .cur_ten_bit  (cur_ten_bit),
  .cur_rd       (cur_rd),
  .cur_hdr_only (cur_hdr_only),
  .cur_addr     (cur_addr)
);

// File: tb/test_i2c_addr_seq.sv
module test_i2c_addr_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b1;
  logic       cfg_we = 1'b0, cfg_start = 1'b0, cfg_ten_bit = 1'b0, cfg_rd = 1'b0, cfg_hdr_only = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic       arb_lost = 1'b0, timeout = 1'b0;
  logic       cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic       start_pend, start_clr, done, nack;
  logic       cur_ten_bit, cur_rd, cur_hdr_only;
  logic [9:0] cur_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [1:0] exp_op [0:4];
  logic [7:0] exp_b  [0:4];
  int         exp_n;

  i2c_addr_seq i_i2c_addr_seq (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic void build(input logic ten, input logic rd, input logic hdr, input logic [9:0] a);
    logic [7:0] hw, hr;
    hw = 8'hF0 | 8'((a >> 8) << 1);
    hr = hw | 8'h01;
    if (!ten) begin
      exp_n = 2; exp_op[0] = 2'd0; exp_b[0] = 8'h00;
      exp_op[1] = 2'd2; exp_b[1] = 8'(((a >> 1) & 10'h7F) << 1) | 8'(rd);
    end else if (!rd) begin
      exp_n = 3; exp_op[0] = 2'd0; exp_b[0] = 8'h00;
      exp_op[1] = 2'd2; exp_b[1] = hw;
      exp_op[2] = 2'd2; exp_b[2] = 8'(a & 10'hFF);
    end else if (!hdr) begin
      exp_n = 5; exp_op[0] = 2'd0; exp_b[0] = 8'h00;
      exp_op[1] = 2'd2; exp_b[1] = hw;
      exp_op[2] = 2'd2; exp_b[2] = 8'(a & 10'hFF);
      exp_op[3] = 2'd1; exp_b[3] = 8'h00;
      exp_op[4] = 2'd2; exp_b[4] = hr;
    end else begin
      exp_n = 2; exp_op[0] = 2'd1; exp_b[0] = 8'h00;
      exp_op[1] = 2'd2; exp_b[1] = hr;
    end
  endfunction

  task automatic write_cfg(input logic st, input logic ten, input logic rd, input logic hdr, input logic [9:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_start = st; cfg_ten_bit = ten; cfg_rd = rd; cfg_hdr_only = hdr; cfg_addr = a;
    @(negedge clk);
    cfg_we = 1'b0; cfg_start = 1'b0;
  endtask

  task automatic wait_valid(input string req, output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (cmd_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    if (!seen) check(1'b0, req, 0, 1);
  endtask

  // one command: compare, handshake, respond; ends at the negedge after the response edge
  task automatic do_step(input int i, input logic ack, input int hold, input string req);
    logic seen;
    wait_valid(req, seen);
    if (!seen) return;
    check(cmd_op == exp_op[i] && (exp_op[i] != 2'd2 || cmd_byte == exp_b[i]), req,
          {cmd_op, cmd_byte}, {exp_op[i], exp_b[i]});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(cmd_valid && cmd_op == exp_op[i] && (exp_op[i] != 2'd2 || cmd_byte == exp_b[i]),
            "R10 hold", {cmd_valid, cmd_op, cmd_byte}, {1'b1, exp_op[i], exp_b[i]});
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    rsp_valid = 1'b1; rsp_ack = ack;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_ack = 1'b0;
  endtask

  // conditions are always answered with ack=0 to show it is not an error (R7)
  task automatic run_txn(input logic ten, input logic rd, input logic hdr, input logic [9:0] a,
                         input int nack_at, input int hold, input string req);
    build(ten, rd, hdr, a);
    write_cfg(1'b1, ten, rd, hdr, a);
    for (int i = 0; i < exp_n; i++) begin
      do_step(i, (exp_op[i] == 2'd2) && (i != nack_at), hold, req);
      if (i == nack_at) begin
        check(nack && !done && !start_pend && start_clr, "R7 nack abort",
              {nack, done, start_pend, start_clr}, 4'b1001);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check(!cmd_valid && !nack, "R7 no command after nack", {cmd_valid, nack}, 0);
        end
        return;
      end
    end
    check(done && !nack && !start_pend && start_clr, "R6 done", {done, nack, start_pend, start_clr}, 4'b1001);
    @(negedge clk);
    check(!done && !start_clr && !cmd_valid, "R6 done one cycle", {done, start_clr, cmd_valid}, 0);
  endtask

  task automatic abort_case(input int kind, input logic in_wait, input string req);
    logic seen;
    build(1'b1, 1'b1, 1'b0, 10'h2A5);
    write_cfg(1'b1, 1'b1, 1'b1, 1'b0, 10'h2A5);
    wait_valid(req, seen);
    if (in_wait) begin
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
    end
    if (kind == 0) arb_lost = 1'b1;
    else if (kind == 1) timeout = 1'b1;
    else enable = 1'b0;
    @(negedge clk);
    arb_lost = 1'b0; timeout = 1'b0; enable = 1'b1;
    check(!start_pend && !cmd_valid && start_clr, req, {start_pend, cmd_valid, start_clr}, 3'b001);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cmd_valid && !start_pend && !done, req, {cmd_valid, start_pend, done}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!start_pend && !cmd_valid && !done && !nack && !start_clr && cur_addr == 0 &&
          !cur_ten_bit && !cur_rd && !cur_hdr_only, "R1 reset state",
          {start_pend, cmd_valid, done, nack, start_clr, cur_addr}, 0);

    // exhaustive address sweeps over every sequence shape
    for (int a = 0; a < 1024; a++) run_txn(1'b0, 1'b0, 1'b0, 10'(a), -1, 0, "R2 7-bit write");
    for (int a = 0; a < 1024; a++) run_txn(1'b0, 1'b1, 1'b1, 10'(a), -1, 0, "R2 7-bit read");
    for (int a = 0; a < 1024; a++) run_txn(1'b1, 1'b0, a[0], 10'(a), -1, 0, "R3 10-bit write");
    for (int a = 0; a < 1024; a++) run_txn(1'b1, 1'b1, 1'b0, 10'(a), -1, 0, "R4 10-bit read full");
    for (int a = 0; a < 1024; a++) run_txn(1'b1, 1'b1, 1'b1, 10'(a), -1, 0, "R5 10-bit read header only");

    // stalled handshake
    run_txn(1'b1, 1'b1, 1'b0, 10'h3C3, -1, 3, "R10 stalled full read");
    run_txn(1'b0, 1'b0, 1'b0, 10'h155, -1, 2, "R10 stalled 7-bit");

    // nack on each address byte position
    run_txn(1'b0, 1'b0, 1'b0, 10'h0A4, 1, 0, "R7 nack 7-bit");
    run_txn(1'b1, 1'b1, 1'b0, 10'h1F0, 1, 0, "R7 nack header");
    run_txn(1'b1, 1'b1, 1'b0, 10'h1F0, 2, 0, "R7 nack second byte");
    run_txn(1'b1, 1'b1, 1'b0, 10'h1F0, 4, 0, "R7 nack read header");
    run_txn(1'b1, 1'b1, 1'b1, 10'h0FF, 1, 0, "R7 nack header-only");

    // aborts while offering and while waiting for the response
    abort_case(0, 1'b0, "R8 arbitration loss during offer");
    abort_case(1, 1'b1, "R8 timeout during wait");
    abort_case(2, 1'b1, "R8 enable low during wait");
    abort_case(0, 1'b1, "R8 arbitration loss during wait");

    // start write while disabled is not taken
    @(negedge clk);
    enable = 1'b0;
    cfg_we = 1'b1; cfg_start = 1'b1; cfg_ten_bit = 1'b0; cfg_rd = 1'b0; cfg_hdr_only = 1'b0; cfg_addr = 10'h012;
    @(negedge clk);
    cfg_we = 1'b0; cfg_start = 1'b0; enable = 1'b1;
    @(negedge clk);
    check(!start_pend && !cmd_valid, "R8 start while disabled", {start_pend, cmd_valid}, 0);

    // writes during a pending request are ignored
    build(1'b1, 1'b0, 1'b0, 10'h2D6);
    write_cfg(1'b1, 1'b1, 1'b0, 1'b0, 10'h2D6);
    write_cfg(1'b1, 1'b0, 1'b1, 1'b1, 10'h111);
    check(cur_addr == 10'h2D6 && cur_ten_bit && !cur_rd && !cur_hdr_only, "R9 fields locked",
          {cur_ten_bit, cur_rd, cur_hdr_only, cur_addr}, {3'b100, 10'h2D6});
    for (int i = 0; i < exp_n; i++) begin
      do_step(i, exp_op[i] == 2'd2, 0, "R9 bytes unchanged");
      if (i == 1) write_cfg(1'b0, 1'b0, 1'b1, 1'b0, 10'h3FF);
    end
    check(done && cur_addr == 10'h2D6, "R9 locked sequence completes", {done, cur_addr}, {1'b1, 10'h2D6});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule